// File: doc/BRIEF.md
# Real-time clock register port

This block is the host-facing register file of a real-time clock. It is reached through two byte-wide locations: an index port and a data port. The host first writes an index to the index port. It then reads or writes the selected location through the data port. Indices 0x00 to 0x09 select a plain array of time and date bytes. The array is preset at reset from an initial time given as parameters. Indices 0x0A to 0x0D select four status registers.

Status register A has a fixed time-base and rate setting. Every read of it flips its update-in-progress flag, so software that polls the flag always sees it change. Status register B holds the mode bits. Its periodic-interrupt-enable bit starts or stops a self-rearming interval timer, which emits a one-cycle interrupt pulse at a fixed cycle interval. Registers C and D always read as zero.

Illegal index writes and unsupported register values are refused. Each one is reported by a one-cycle flag pulse.

The timer is a two-state machine:
- `TMR_IDLE`: stopped.
- `TMR_RUN`: counting down.

It has two transitions:
- arm: `TMR_IDLE` to `TMR_RUN`, on an accepted status B write with the enable bit set.
- disarm: `TMR_RUN` to `TMR_IDLE`, on an accepted status B write with the enable bit clear.

Top module: `rtc_reg_port`

## Requirements
- R1: A write to the index port with a value of 0x00 to 0x0D stores that index. A value above 0x0D pulses `idx_err` high for one cycle and leaves the stored index unchanged. A read of the index port returns the stored index. The index resets to 0x00.
- R2: With the index below 0x0A, a data-port write stores the byte in that time slot and a data-port read returns it. Read data appears on `acc_rdata` one cycle after the read, holds between reads, and resets to 0x00.
- R3: Status register A resets to 0x26. Bit 7 is the update-in-progress flag, bits 6:4 = 010 select the 32.768 kHz time base, and bits 3:0 = 0110 select the 1024 Hz rate. A data write of exactly 0x26 is stored. Any other value pulses `unsup_err` and leaves register A unchanged.
- R4: Each data-port read of status register A inverts bit 7 of the register and returns the updated value.
- R5: Status register B resets to 0x46. Bit 6 is periodic-interrupt enable, bit 3 is square-wave enable, bit 2 is binary mode, and bit 1 is 24-hour mode. A write is stored only when the value with bits 6 and 3 cleared equals 0x06. Otherwise it pulses `unsup_err` and register B is unchanged.
- R6: An accepted write to B with bit 6 set starts the timer if it is stopped, and does not restart a running timer. An accepted write with bit 6 clear stops the timer, and no further pulse follows. The timer runs from reset.
- R7: While running, `periodic_irq` is a one-cycle pulse every INTERVAL cycles. When started by a write, the first pulse is high in the cycle that begins INTERVAL-1 clock edges after the write edge.
- R8: Data-port reads of indices 0x0C and 0x0D return 0x00. Data writes to them pulse `unsup_err` and have no effect.
- R9: The time bytes reset as follows:
  - index 0: seconds
  - index 2: minutes
  - index 4: hours
  - index 6: day of week, plus one (Sunday = 1)
  - index 7: day of month
  - index 8: month, plus one (January = 1)
  - index 9: year

  When YEAR_BCD is set, the year is stored as two BCD digits of (years since 1900) mod 100; otherwise it is stored as the low byte of the years since 1900. Indices 1, 3 and 5 reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Write strobe; takes priority over acc_rd |
| acc_rd | input | 1 | Read strobe |
| acc_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read data |
| idx_err | output | 1 | One-cycle pulse: index out of range |
| unsup_err | output | 1 | One-cycle pulse: unsupported status write |
| periodic_irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
The bench builds the block with INTERVAL = 12, so several full periods, a stop, a restart and a no-restart write all fit in a few hundred cycles. It sets YEAR_BCD = 1 with year 124, a Sunday and a month of 6. This exercises the modulo-100 BCD conversion and both one-based offsets in the reset image, which the default build leaves out. All other parameters stay at their defaults.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;

    localparam int unsigned IDX_W       = 4;
    localparam int unsigned DATA_W      = 8;
    localparam int unsigned NUM_TIME_B  = 10;
    localparam logic [7:0]  IDX_MAX     = 8'h0D;

    localparam logic [IDX_W-1:0] IDX_STAT_A = 4'hA;
    localparam logic [IDX_W-1:0] IDX_STAT_B = 4'hB;
    localparam logic [IDX_W-1:0] IDX_STAT_C = 4'hC;
    localparam logic [IDX_W-1:0] IDX_STAT_D = 4'hD;

    localparam logic [7:0] STA_UIP      = 8'h80;
    localparam logic [7:0] STA_RESET    = 8'h26;
    localparam logic [7:0] STB_PIE      = 8'h40;
    localparam logic [7:0] STB_SQW      = 8'h08;
    localparam logic [7:0] STB_FIXED    = 8'h06;
    localparam logic [7:0] STB_RESET    = 8'h46;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    function automatic logic [7:0] to_bcd2(input int unsigned v);
        int unsigned m;
        m = v % 100;
        return {4'(m / 10), 4'(m % 10)};
    endfunction

endpackage

// File: rtl/rtc_time_bytes.sv
module rtc_time_bytes
    import rtc_port_pkg::*;
#(
    parameter int unsigned NUM_BYTES = NUM_TIME_B,
    parameter int unsigned INIT_SEC  = 0,
    parameter int unsigned INIT_MIN  = 0,
    parameter int unsigned INIT_HOUR = 0,
    parameter int unsigned INIT_WDAY = 0,
    parameter int unsigned INIT_MDAY = 1,
    parameter int unsigned INIT_MON  = 0,
    parameter int unsigned INIT_YEAR = 100,
    parameter bit          YEAR_BCD  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    function automatic logic [7:0] init_byte(input int unsigned slot);
        case (slot)
            0:       return 8'(INIT_SEC);
            2:       return 8'(INIT_MIN);
            4:       return 8'(INIT_HOUR);
            6:       return 8'(INIT_WDAY + 1);
            7:       return 8'(INIT_MDAY);
            8:       return 8'(INIT_MON + 1);
            9:       return YEAR_BCD ? to_bcd2(INIT_YEAR) : 8'(INIT_YEAR);
            default: return 8'h00;
        endcase
    endfunction

    logic [7:0] bytes_q [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[g] <= init_byte(g);
            end else if (we && (addr == IDX_W'(g))) begin
                bytes_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (addr == IDX_W'(i)) rdata = bytes_q[i];
        end
    end

endmodule

// File: rtl/rtc_periodic_timer.sv
module rtc_periodic_timer
    import rtc_port_pkg::*;
#(
    parameter int unsigned INTERVAL = 48828
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    output logic irq
);

    localparam int unsigned CW     = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    tmr_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_RUN;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE: if (arm)    state_d = TMR_RUN;
            TMR_RUN:  if (disarm) state_d = TMR_IDLE;
        endcase
    end

    // Interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else begin
            unique case (state_q)
                TMR_IDLE: if (arm) cnt_q <= RELOAD;
                TMR_RUN: begin
                    if (!disarm) begin
                        if (cnt_q == '0) cnt_q <= RELOAD;
                        else             cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            TMR_IDLE: irq = 1'b0;
            TMR_RUN:  irq = (cnt_q == '0);
        endcase
    end

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_irq_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !disarm) |=> (cnt_q == RELOAD) && (state_q == TMR_RUN));
    p_stop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> !irq);
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN && arm && !disarm && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port
    import rtc_port_pkg::*;
#(
    parameter int unsigned INTERVAL  = 48828,
    parameter int unsigned INIT_SEC  = 0,
    parameter int unsigned INIT_MIN  = 0,
    parameter int unsigned INIT_HOUR = 0,
    parameter int unsigned INIT_WDAY = 0,
    parameter int unsigned INIT_MDAY = 1,
    parameter int unsigned INIT_MON  = 0,
    parameter int unsigned INIT_YEAR = 100,
    parameter bit          YEAR_BCD  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_wr,
    input  logic       acc_rd,
    input  logic       acc_sel,
    input  logic [7:0] acc_wdata,
    output logic [7:0] acc_rdata,
    output logic       idx_err,
    output logic       unsup_err,
    output logic       periodic_irq
);

    logic [IDX_W-1:0] index_q;
    logic [7:0]       stat_a_q, stat_b_q, rdata_q;
    logic             idx_err_q, unsup_q;

    logic idx_wr, idx_rd, data_wr, data_rd;
    logic idx_ok, in_time, a_ok, b_ok, b_wr_ok, unsup_d;
    logic tb_we, arm, disarm;
    logic [7:0] tb_rdata;

    // Access decode
    always_comb begin
        idx_wr  = acc_wr && !acc_sel;
        data_wr = acc_wr &&  acc_sel;
        idx_rd  = acc_rd && !acc_wr && !acc_sel;
        data_rd = acc_rd && !acc_wr &&  acc_sel;

        idx_ok  = (acc_wdata <= IDX_MAX);
        in_time = (index_q < IDX_W'(NUM_TIME_B));
        a_ok    = (acc_wdata == STA_RESET);
        b_ok    = ((acc_wdata & ~(STB_PIE | STB_SQW)) == STB_FIXED);
        b_wr_ok = data_wr && (index_q == IDX_STAT_B) && b_ok;

        tb_we   = data_wr && in_time;
        arm     = b_wr_ok &&  acc_wdata[6];
        disarm  = b_wr_ok && !acc_wdata[6];

        unsup_d = data_wr && (((index_q == IDX_STAT_A) && !a_ok) ||
                              ((index_q == IDX_STAT_B) && !b_ok) ||
                               (index_q == IDX_STAT_C) ||
                               (index_q == IDX_STAT_D));
    end

    rtc_time_bytes #(
        .NUM_BYTES (NUM_TIME_B),
        .INIT_SEC  (INIT_SEC),
        .INIT_MIN  (INIT_MIN),
        .INIT_HOUR (INIT_HOUR),
        .INIT_WDAY (INIT_WDAY),
        .INIT_MDAY (INIT_MDAY),
        .INIT_MON  (INIT_MON),
        .INIT_YEAR (INIT_YEAR),
        .YEAR_BCD  (YEAR_BCD)
    ) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tb_we),
        .addr  (index_q),
        .wdata (acc_wdata),
        .rdata (tb_rdata)
    );

    rtc_periodic_timer #(
        .INTERVAL (INTERVAL)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .disarm (disarm),
        .irq    (periodic_irq)
    );

    // Index register
    always_ff @(posedge clk) begin
        if (!rst_n)                index_q <= '0;
        else if (idx_wr && idx_ok) index_q <= acc_wdata[IDX_W-1:0];
    end

    // Status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_a_q <= STA_RESET;
            stat_b_q <= STB_RESET;
        end else begin
            if (data_wr && (index_q == IDX_STAT_A) && a_ok)
                stat_a_q <= acc_wdata;
            else if (data_rd && (index_q == IDX_STAT_A))
                stat_a_q <= stat_a_q ^ STA_UIP;
            if (b_wr_ok)
                stat_b_q <= acc_wdata;
        end
    end

    // Read data and flag pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q   <= 8'h00;
            idx_err_q <= 1'b0;
            unsup_q   <= 1'b0;
        end else begin
            idx_err_q <= idx_wr && !idx_ok;
            unsup_q   <= unsup_d;
            if (idx_rd) begin
                rdata_q <= 8'(index_q);
            end else if (data_rd) begin
                if (in_time)                       rdata_q <= tb_rdata;
                else if (index_q == IDX_STAT_A)    rdata_q <= stat_a_q ^ STA_UIP;
                else if (index_q == IDX_STAT_B)    rdata_q <= stat_b_q;
                else                               rdata_q <= 8'h00;
            end
        end
    end

    assign acc_rdata = rdata_q;
    assign idx_err   = idx_err_q;
    assign unsup_err = unsup_q;

    p_index_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        index_q <= IDX_W'(IDX_MAX));
    p_bad_index_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && (acc_wdata > IDX_MAX)) |=> idx_err && $stable(index_q));
    p_a_fixed_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_a_q[6:0] == STA_RESET[6:0]);
    p_uip_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && (index_q == IDX_STAT_A)) |=>
            (acc_rdata == stat_a_q) && (acc_rdata[7] != $past(stat_a_q[7])));
    p_b_fixed_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_b_q & ~(STB_PIE | STB_SQW)) == STB_FIXED);
    p_cd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && (index_q >= IDX_STAT_C)) |=> acc_rdata == 8'h00);

endmodule

// File: tb/rtc_reg_port_tb.sv
`timescale 1ns/1ps
module rtc_reg_port_tb;

    localparam int unsigned IVL = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_wr = 1'b0, acc_rd = 1'b0, acc_sel = 1'b0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] acc_rdata;
    logic       idx_err, unsup_err, periodic_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_reg_port #(
        .INTERVAL  (IVL),
        .INIT_SEC  (45),
        .INIT_MIN  (30),
        .INIT_HOUR (13),
        .INIT_WDAY (0),
        .INIT_MDAY (17),
        .INIT_MON  (6),
        .INIT_YEAR (124),
        .YEAR_BCD  (1'b1)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_wr       (acc_wr),
        .acc_rd       (acc_rd),
        .acc_sel      (acc_sel),
        .acc_wdata    (acc_wdata),
        .acc_rdata    (acc_rdata),
        .idx_err      (idx_err),
        .unsup_err    (unsup_err),
        .periodic_irq (periodic_irq)
    );

    typedef struct packed {
        logic       wr;
        logic       sel;
        logic [7:0] data;
        logic [7:0] exp;
        logic       e_idx;
        logic       e_uns;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 52;
    localparam vec_t VECS [NV] = '{
        // R9 reset image, BCD year, one-based month and weekday; R1 index writes
        '{1'b1,1'b0,8'h00,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h2D,1'b0,1'b0,4'd9},
        '{1'b1,1'b0,8'h09,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h24,1'b0,1'b0,4'd9},
        '{1'b1,1'b0,8'h08,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h07,1'b0,1'b0,4'd9},
        '{1'b1,1'b0,8'h06,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h01,1'b0,1'b0,4'd9},
        '{1'b1,1'b0,8'h07,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h11,1'b0,1'b0,4'd9},
        '{1'b1,1'b0,8'h04,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h0D,1'b0,1'b0,4'd9},
        '{1'b1,1'b0,8'h02,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h1E,1'b0,1'b0,4'd9},
        '{1'b1,1'b0,8'h01,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,4'd9},
        // R2 byte array write/read; R1 index read-back and rejected indices
        '{1'b1,1'b1,8'h5A,8'h00,1'b0,1'b0,4'd2}, '{1'b0,1'b1,8'h00,8'h5A,1'b0,1'b0,4'd2},
        '{1'b0,1'b0,8'h00,8'h01,1'b0,1'b0,4'd1}, '{1'b1,1'b0,8'h0E,8'h00,1'b1,1'b0,4'd1},
        '{1'b0,1'b0,8'h00,8'h01,1'b0,1'b0,4'd1}, '{1'b1,1'b0,8'hFF,8'h00,1'b1,1'b0,4'd1},
        '{1'b0,1'b0,8'h00,8'h01,1'b0,1'b0,4'd1}, '{1'b1,1'b0,8'h03,8'h00,1'b0,1'b0,4'd1},
        '{1'b1,1'b1,8'h99,8'h00,1'b0,1'b0,4'd2}, '{1'b0,1'b1,8'h00,8'h99,1'b0,1'b0,4'd2},
        '{1'b1,1'b0,8'h02,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h1E,1'b0,1'b0,4'd2},
        // R4 toggling reads of A; R3 write filter of A
        '{1'b1,1'b0,8'h0A,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'hA6,1'b0,1'b0,4'd4},
        '{1'b0,1'b1,8'h00,8'h26,1'b0,1'b0,4'd4}, '{1'b0,1'b1,8'h00,8'hA6,1'b0,1'b0,4'd4},
        '{1'b1,1'b1,8'h27,8'h00,1'b0,1'b1,4'd3}, '{1'b0,1'b1,8'h00,8'h26,1'b0,1'b0,4'd3},
        '{1'b1,1'b1,8'h26,8'h00,1'b0,1'b0,4'd3}, '{1'b0,1'b1,8'h00,8'hA6,1'b0,1'b0,4'd3},
        // R5 register B reset and write filter
        '{1'b1,1'b0,8'h0B,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h46,1'b0,1'b0,4'd5},
        '{1'b1,1'b1,8'h4E,8'h00,1'b0,1'b0,4'd5}, '{1'b0,1'b1,8'h00,8'h4E,1'b0,1'b0,4'd5},
        '{1'b1,1'b1,8'h47,8'h00,1'b0,1'b1,4'd5}, '{1'b0,1'b1,8'h00,8'h4E,1'b0,1'b0,4'd5},
        '{1'b1,1'b1,8'h02,8'h00,1'b0,1'b1,4'd5}, '{1'b0,1'b1,8'h00,8'h4E,1'b0,1'b0,4'd5},
        // R8 registers C and D
        '{1'b1,1'b0,8'h0C,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,4'd8},
        '{1'b1,1'b1,8'hFF,8'h00,1'b0,1'b1,4'd8}, '{1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,4'd8},
        '{1'b1,1'b0,8'h0D,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,4'd8},
        '{1'b1,1'b0,8'h0A,8'h00,1'b0,1'b0,4'd1}, '{1'b0,1'b1,8'h00,8'h26,1'b0,1'b0,4'd4}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One access: drive after a falling edge, sample at the next falling edge.
    task automatic access(input logic wr, input logic sel, input logic [7:0] d);
        @(negedge clk);
        acc_wr = wr; acc_rd = !wr; acc_sel = sel; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0; acc_wdata = 8'h00;
    endtask

    task automatic wait_irq(input int limit, output int at);
        at = -1;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (periodic_irq) begin
                at = cyc;
                break;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int t0, t1, t_w, hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: R2 read data zero, R1 no index error, R3 no unsupported flag
        check(acc_rdata == 8'h00, "R2", acc_rdata, 0);
        check(idx_err == 1'b0, "R1", idx_err, 0);
        check(unsup_err == 1'b0, "R3", unsup_err, 0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].sel, VECS[i].data);
            n_chk++;
            if ((!VECS[i].wr && acc_rdata !== VECS[i].exp) ||
                idx_err !== VECS[i].e_idx || unsup_err !== VECS[i].e_uns) begin
                n_fail++;
                $display("FAIL R%0d vec %0d: actual rd=0x%0h ie=%0b ue=%0b expected rd=0x%0h ie=%0b ue=%0b",
                         VECS[i].req, i, acc_rdata, idx_err, unsup_err,
                         VECS[i].exp, VECS[i].e_idx, VECS[i].e_uns);
            end
        end

        // R7: timer running since reset; period and pulse width
        wait_irq(3*IVL, t0);
        check(t0 >= 0, "R7", t0, 1);
        @(negedge clk);
        check(periodic_irq == 1'b0, "R7", periodic_irq, 0);
        wait_irq(3*IVL, t1);
        check(t1 - t0 == IVL, "R7", t1 - t0, IVL);

        // R6: clearing enable stops the pulses
        access(1'b1, 1'b0, 8'h0B);
        access(1'b1, 1'b1, 8'h06);
        hits = 0;
        for (int k = 0; k < 3*IVL; k++) begin
            @(negedge clk);
            if (periodic_irq) hits++;
        end
        check(hits == 0, "R6", hits, 0);

        // R7: first pulse INTERVAL-1 edges after the arming write
        access(1'b1, 1'b1, 8'h46);
        t_w = cyc;
        wait_irq(3*IVL, t0);
        check(t0 - t_w == IVL - 1, "R7", t0 - t_w, IVL - 1);

        // R6: a second enable write while running does not restart the count
        access(1'b1, 1'b1, 8'h46);
        wait_irq(3*IVL, t1);
        check(t1 - t0 == IVL, "R6", t1 - t0, IVL);

        // R9: reset restores a written time byte and the index
        access(1'b1, 1'b0, 8'h01);
        access(1'b1, 1'b1, 8'h77);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        access(1'b0, 1'b0, 8'h00);
        check(acc_rdata == 8'h00, "R1", acc_rdata, 0);
        access(1'b1, 1'b0, 8'h01);
        access(1'b0, 1'b1, 8'h00);
        check(acc_rdata == 8'h00, "R9", acc_rdata, 0);
        // R2: read data holds between reads
        repeat (3) @(negedge clk);
        check(acc_rdata == 8'h00, "R2", acc_rdata, 0);

        finish_run();
    end

endmodule